// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Interval Timer

This block keeps wall-clock time and a calendar date: seconds, minutes, hours, day of month, month, a two-digit year and a day-of-week index. It advances by one second on each cycle where the single-cycle `tick_i` enable is high. That enable is produced elsewhere from a slow reference clock. The host reaches all state through a flat register file. Writes take one cycle, and reads are combinational on `rd_addr_i`. The host can rewrite any time field while counting goes on, and fields it does not write keep counting.

A date/time alarm compares the live year, month, day, hour and minute against programmed values. Each of those five fields has its own enable bit, so the alarm can watch any subset, down to a single field. The alarm raises a one-cycle pulse when the enabled fields first agree with the time at second 00.

A separate interval timer counts ticks. In one-shot mode it raises a pulse once after N ticks. In periodic mode it raises a pulse every N ticks.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads second 0, minute 0, hour 0, day 1, month 1, year 0, day-of-week 0. Each tick adds one second. Second 59 wraps to 0 and carries into the minute, minute 59 wraps to 0 and carries into the hour, and hour 23 wraps to 0 and carries into the date.
- R2: The last day of a month is 30 for months 4, 6, 9 and 11, and 31 for the other months except 2. Month 2 ends on day 29 when the binary year value is a multiple of 4, year 0 included, and on day 28 otherwise. Past the last day the date moves to day 1 of the next month. Month 12 wraps to month 1 and increments the year, and year 99 wraps to 0.
- R3: The day-of-week index goes up by one at each midnight and wraps from 6 to 0.
- R4: A host write to one time field replaces only that field, and the other fields keep their values and keep counting. If the write lands in the same cycle as a tick, the written value is stored and no field advances in that cycle. Counting resumes at the next tick.
- R5: Register map, 4-bit address, values in binary and right-aligned:
  - 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year, 6 day-of-week.
  - 7 to 11: alarm minute, hour, day, month and year.
  - 12: alarm enable. Bit 0 minute, bit 1 hour, bit 2 day, bit 3 month, bit 4 year.
  - 13: timer interval in ticks.
  - 14: timer control. Bit 0 run, bit 1 periodic.
  - Every register reads back what was written or counted. Address 15 reads 0.
- R6: When the enabled alarm fields all match and the second is 0, `alarm_irq_o` is high for exactly one cycle, the cycle after the time reached that state. It does not pulse again while the condition holds. Fields that are not enabled are ignored.
- R7: An alarm enable value of zero disables the alarm completely.
- R8: A write to timer control with the run bit set loads the interval. In one-shot mode `timer_irq_o` pulses for one cycle after the N-th following tick. The run bit then reads 0 and no further pulse follows.
- R9: In periodic mode the timer pulses after every N ticks and the run bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second enable, high for one cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| alarm_irq_o | output | 1 | Alarm pulse |
| timer_irq_o | output | 1 | Interval timer pulse |

## Verification
The hardest states to reach are the calendar edges, such as February 28/29 in leap and common years, April 30 and December 31 of year 99. Reaching them by ticking alone would take millions of cycles. The bench instead uses the host's own write path to place the clock at 23:59:59 on the day in question and then issues one tick. The same path re-arms 23:59:59 between steps, which also exercises rewriting the time while counting continues. A write coinciding with a tick is driven by raising both strobes at the same edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_SEC  = 4'd0;
  localparam addr_t A_MIN  = 4'd1;
  localparam addr_t A_HOUR = 4'd2;
  localparam addr_t A_DAY  = 4'd3;
  localparam addr_t A_MON  = 4'd4;
  localparam addr_t A_YEAR = 4'd5;
  localparam addr_t A_WDAY = 4'd6;
  localparam addr_t A_AMIN = 4'd7;
  localparam addr_t A_AHR  = 4'd8;
  localparam addr_t A_ADAY = 4'd9;
  localparam addr_t A_AMON = 4'd10;
  localparam addr_t A_AYR  = 4'd11;
  localparam addr_t A_AEN  = 4'd12;
  localparam addr_t A_TIVL = 4'd13;
  localparam addr_t A_TCTL = 4'd14;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] day;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] mins;
    logic [5:0] secs;
  } rtc_time_t;

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2: month_len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      default: month_len = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  addr_t      wr_addr_i,
  input  logic [6:0] wr_data_i,
  output rtc_time_t  time_o
);
  rtc_time_t cur_q, nxt;
  logic time_wr, leap;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

  assign time_wr = wr_en_i && (wr_addr_i <= A_WDAY);
  assign leap    = (cur_q.year[1:0] == 2'b00);

  always_comb begin
    sec_wrap  = cur_q.secs >= 6'd59;
    min_wrap  = sec_wrap && (cur_q.mins >= 6'd59);
    hour_wrap = min_wrap && (cur_q.hour >= 5'd23);
    day_wrap  = hour_wrap && (cur_q.day >= month_len(cur_q.mon, leap));
    mon_wrap  = day_wrap && (cur_q.mon >= 4'd12);
    nxt = cur_q;
    nxt.secs = sec_wrap ? 6'd0 : cur_q.secs + 6'd1;
    if (sec_wrap) nxt.mins = (cur_q.mins >= 6'd59) ? 6'd0 : cur_q.mins + 6'd1;
    if (min_wrap) nxt.hour = (cur_q.hour >= 5'd23) ? 5'd0 : cur_q.hour + 5'd1;
    if (hour_wrap) begin
      nxt.wday = (cur_q.wday >= 3'd6) ? 3'd0 : cur_q.wday + 3'd1;
      nxt.day  = day_wrap ? 5'd1 : cur_q.day + 5'd1;
    end
    if (day_wrap) nxt.mon = mon_wrap ? 4'd1 : cur_q.mon + 4'd1;
    if (mon_wrap) nxt.year = (cur_q.year >= 7'd99) ? 7'd0 : cur_q.year + 7'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '{year: 7'd0, mon: 4'd1, day: 5'd1, wday: 3'd0,
                 hour: 5'd0, mins: 6'd0, secs: 6'd0};
    end else if (time_wr) begin
      // host write wins over a coincident tick
      case (wr_addr_i)
        A_SEC:   cur_q.secs <= wr_data_i[5:0];
        A_MIN:   cur_q.mins <= wr_data_i[5:0];
        A_HOUR:  cur_q.hour <= wr_data_i[4:0];
        A_DAY:   cur_q.day  <= wr_data_i[4:0];
        A_MON:   cur_q.mon  <= wr_data_i[3:0];
        A_YEAR:  cur_q.year <= wr_data_i;
        default: cur_q.wday <= wr_data_i[2:0];
      endcase
    end else if (tick_i) begin
      cur_q <= nxt;
    end
  end

  assign time_o = cur_q;

  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_wr && cur_q.secs < 6'd59) |=> cur_q.secs == $past(cur_q.secs) + 6'd1); // R1
  AST_LEAP_FEB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_wr && cur_q.mon == 4'd2 && cur_q.day == 5'd28 && cur_q.year[1:0] == 2'b00
     && cur_q.hour == 5'd23 && cur_q.mins == 6'd59 && cur_q.secs == 6'd59) |=> cur_q.day == 5'd29); // R2
  AST_WDAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !time_wr && cur_q.wday == 3'd6 && cur_q.hour == 5'd23 && cur_q.mins == 6'd59
     && cur_q.secs == 6'd59) |=> cur_q.wday == 3'd0); // R3
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SEC) |=> cur_q.secs == $past(wr_data_i[5:0])); // R4
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  addr_t      wr_addr_i,
  input  logic [6:0] wr_data_i,
  input  logic [6:0] year_i,
  input  logic [3:0] mon_i,
  input  logic [4:0] day_i,
  input  logic [4:0] hour_i,
  input  logic [5:0] mins_i,
  input  logic [5:0] secs_i,
  output logic [5:0] a_min_o,
  output logic [4:0] a_hour_o,
  output logic [4:0] a_day_o,
  output logic [3:0] a_mon_o,
  output logic [6:0] a_year_o,
  output logic [4:0] a_en_o,
  output logic       irq_o
);
  logic match, hit, hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_min_o <= '0; a_hour_o <= '0; a_day_o <= 5'd1;
      a_mon_o <= 4'd1; a_year_o <= '0; a_en_o <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_AMIN:  a_min_o  <= wr_data_i[5:0];
        A_AHR:   a_hour_o <= wr_data_i[4:0];
        A_ADAY:  a_day_o  <= wr_data_i[4:0];
        A_AMON:  a_mon_o  <= wr_data_i[3:0];
        A_AYR:   a_year_o <= wr_data_i;
        A_AEN:   a_en_o   <= wr_data_i[4:0];
        default: ;
      endcase
    end
  end

  assign match = (!a_en_o[0] || mins_i == a_min_o) && (!a_en_o[1] || hour_i == a_hour_o) &&
                 (!a_en_o[2] || day_i  == a_day_o) && (!a_en_o[3] || mon_i  == a_mon_o) &&
                 (!a_en_o[4] || year_i == a_year_o);
  assign hit = (a_en_o != 5'd0) && match && (secs_i == 6'd0);

  // rising edge of the match condition gives a single pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      hit_q <= hit;
      irq_o <= hit && !hit_q;
    end
  end

  AST_ALARM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R6
  AST_ALARM_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(secs_i) == 6'd0); // R6
  AST_ALARM_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(a_en_o) != 5'd0); // R7
endmodule

// File: rtl/rtc_interval_timer.sv
module rtc_interval_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ivl_wr_i,
  input  logic             ctl_wr_i,
  input  logic [TMR_W-1:0] wr_data_i,
  output logic [TMR_W-1:0] ivl_o,
  output logic             run_o,
  output logic             periodic_o,
  output logic             irq_o
);
  logic [TMR_W-1:0] cnt_q;
  logic expire;

  assign expire = cnt_q <= TMR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ivl_o <= '0;
    else if (ivl_wr_i) ivl_o <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; run_o <= 1'b0; periodic_o <= 1'b0; irq_o <= 1'b0;
    end else if (ctl_wr_i) begin
      run_o      <= wr_data_i[0];
      periodic_o <= wr_data_i[1];
      cnt_q      <= ivl_o;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (tick_i && run_o) begin
        if (expire) begin
          irq_o <= 1'b1;
          cnt_q <= ivl_o;
          if (!periodic_o) run_o <= 1'b0;
        end else begin
          cnt_q <= cnt_q - TMR_W'(1);
        end
      end
    end
  end

  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !periodic_o) |-> !run_o); // R8
  AST_TIMER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i) && $past(run_o)); // R9
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [3:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_irq_o,
  output logic              timer_irq_o
);
  rtc_time_t tm;
  logic [5:0] a_min;
  logic [4:0] a_hour, a_day, a_en;
  logic [3:0] a_mon;
  logic [6:0] a_year;
  logic [DATA_W-1:0] t_ivl;
  logic t_run, t_per;

  rtc_time_core u_core (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i,
    .wr_data_i(wr_data_i[6:0]), .time_o(tm)
  );

  rtc_alarm u_alarm (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i(wr_data_i[6:0]),
    .year_i(tm.year), .mon_i(tm.mon), .day_i(tm.day), .hour_i(tm.hour),
    .mins_i(tm.mins), .secs_i(tm.secs),
    .a_min_o(a_min), .a_hour_o(a_hour), .a_day_o(a_day), .a_mon_o(a_mon),
    .a_year_o(a_year), .a_en_o(a_en), .irq_o(alarm_irq_o)
  );

  rtc_interval_timer #(.TMR_W(DATA_W)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .ivl_wr_i(wr_en_i && wr_addr_i == A_TIVL),
    .ctl_wr_i(wr_en_i && wr_addr_i == A_TCTL),
    .wr_data_i, .ivl_o(t_ivl), .run_o(t_run), .periodic_o(t_per), .irq_o(timer_irq_o)
  );

  always_comb begin
    case (rd_addr_i)
      A_SEC:   rd_data_o = DATA_W'(tm.secs);
      A_MIN:   rd_data_o = DATA_W'(tm.mins);
      A_HOUR:  rd_data_o = DATA_W'(tm.hour);
      A_DAY:   rd_data_o = DATA_W'(tm.day);
      A_MON:   rd_data_o = DATA_W'(tm.mon);
      A_YEAR:  rd_data_o = DATA_W'(tm.year);
      A_WDAY:  rd_data_o = DATA_W'(tm.wday);
      A_AMIN:  rd_data_o = DATA_W'(a_min);
      A_AHR:   rd_data_o = DATA_W'(a_hour);
      A_ADAY:  rd_data_o = DATA_W'(a_day);
      A_AMON:  rd_data_o = DATA_W'(a_mon);
      A_AYR:   rd_data_o = DATA_W'(a_year);
      A_AEN:   rd_data_o = DATA_W'(a_en);
      A_TIVL:  rd_data_o = t_ivl;
      A_TCTL:  rd_data_o = DATA_W'({t_per, t_run});
      default: rd_data_o = '0;
    endcase
  end

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timer_irq_o) |-> $past(tick_i)); // R8
endmodule

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic alarm_irq, timer_irq;
  int total = 0, bad = 0;
  int alarm_cnt = 0, timer_cnt = 0;

  always #10 clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .alarm_irq_o(alarm_irq), .timer_irq_o(timer_irq)
  );

  always @(negedge clk) begin
    if (alarm_irq) alarm_cnt++;
    if (timer_irq) timer_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_addr = 4'(a); #1; v = int'(rd_data);
  endtask

  task automatic expect_reg(input string req, input int a, input int exp);
    int v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int h,
                          input int mi, input int s, input int wd);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y); wr(6, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    expect_reg("R1 reset sec", 0, 0);
    expect_reg("R1 reset min", 1, 0);
    expect_reg("R1 reset hour", 2, 0);
    expect_reg("R1 reset day", 3, 1);
    expect_reg("R1 reset month", 4, 1);
    expect_reg("R1 reset year", 5, 0);
    expect_reg("R1 reset wday", 6, 0);
    expect_reg("R5 unused addr", 15, 0);
  endtask

  task automatic t_rollover();
    set_time(10, 3, 14, 23, 59, 58, 2);
    do_tick();
    expect_reg("R1 sec 59", 0, 59);
    do_tick();
    expect_reg("R1 sec wrap", 0, 0);
    expect_reg("R1 min wrap", 1, 0);
    expect_reg("R1 hour wrap", 2, 0);
    expect_reg("R1 day carry", 3, 15);
    expect_reg("R3 wday step", 6, 3);
    set_time(10, 3, 15, 23, 59, 59, 6);
    do_tick();
    expect_reg("R3 wday wrap", 6, 0);
  endtask

  task automatic t_calendar();
    set_time(24, 2, 28, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 leap feb29 day", 3, 29);
    expect_reg("R2 leap feb29 month", 4, 2);
    wr(2, 23); wr(1, 59); wr(0, 59);
    do_tick();
    expect_reg("R2 leap to mar day", 3, 1);
    expect_reg("R2 leap to mar month", 4, 3);
    set_time(23, 2, 28, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 common feb end", 4, 3);
    set_time(0, 2, 28, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 year 00 leap", 3, 29);
    set_time(5, 4, 30, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 april end day", 3, 1);
    expect_reg("R2 april end month", 4, 5);
    set_time(5, 1, 30, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 jan 31 exists", 3, 31);
    set_time(99, 12, 31, 23, 59, 59, 0);
    do_tick();
    expect_reg("R2 year wrap", 5, 0);
    expect_reg("R2 month wrap", 4, 1);
    expect_reg("R2 day wrap", 3, 1);
  endtask

  task automatic t_write_live();
    set_time(7, 6, 10, 8, 7, 10, 1);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'd30;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    expect_reg("R4 write beats tick sec", 0, 30);
    expect_reg("R4 write beats tick min", 1, 7);
    do_tick();
    expect_reg("R4 tick resumes", 0, 31);
    wr(1, 20);
    expect_reg("R4 other field kept", 0, 31);
    expect_reg("R4 written field", 1, 20);
    do_tick();
    expect_reg("R4 counting continues", 0, 32);
  endtask

  task automatic t_alarm();
    int base;
    wr(7, 5); wr(8, 11); wr(9, 15); wr(10, 4); wr(11, 9);
    expect_reg("R5 alarm hour readback", 8, 11);
    wr(12, 1);
    expect_reg("R5 alarm enable readback", 12, 1);
    set_time(3, 2, 2, 10, 4, 59, 0);
    base = alarm_cnt;
    do_tick(); idle(3);
    chk("R6 minute-only alarm fires", alarm_cnt - base, 1);
    do_tick(); do_tick(); idle(2);
    chk("R6 alarm fires once", alarm_cnt - base, 1);
    wr(12, 3);
    set_time(3, 2, 2, 10, 4, 59, 0);
    base = alarm_cnt;
    do_tick(); idle(3);
    chk("R6 hour mismatch ignored", alarm_cnt - base, 0);
    wr(12, 4);
    set_time(3, 2, 14, 23, 59, 59, 0);
    base = alarm_cnt;
    do_tick(); idle(3);
    chk("R6 day-only alarm fires", alarm_cnt - base, 1);
    wr(12, 0);
    set_time(3, 2, 14, 23, 59, 59, 0);
    base = alarm_cnt;
    do_tick(); idle(3);
    chk("R7 zero enable silent", alarm_cnt - base, 0);
  endtask

  task automatic t_timer();
    int base;
    wr(13, 3);
    expect_reg("R5 interval readback", 13, 3);
    wr(14, 1);
    base = timer_cnt;
    do_tick(); do_tick(); idle(2);
    chk("R8 no early pulse", timer_cnt - base, 0);
    do_tick(); idle(2);
    chk("R8 one-shot pulse", timer_cnt - base, 1);
    expect_reg("R8 run bit cleared", 14, 0);
    do_tick(); do_tick(); do_tick(); do_tick(); idle(2);
    chk("R8 no repeat", timer_cnt - base, 1);
    wr(13, 2); wr(14, 3);
    base = timer_cnt;
    for (int i = 0; i < 4; i++) do_tick();
    idle(2);
    chk("R9 periodic pulses", timer_cnt - base, 2);
    expect_reg("R9 run bit kept", 14, 3);
    wr(14, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rollover();
    t_calendar();
    t_write_live();
    t_alarm();
    t_timer();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule